// File: doc/BRIEF.md
# Six-Bit Programmable Clock-Enable Divider

This block turns one of several source tick streams into a slower tick stream. A single control word holds three fields: a divisor, a parent-source index and a halt flag. The divisor field holds N, and the block emits one single-cycle pulse on `tick_out` for every N+1 ticks seen on the chosen source. Ratios therefore run from 1 to 64. Everything runs on one system clock. The sources and the output are clock enables, not clocks, so no clock switching takes place.

Software programs the word through a plain write strobe and reads it back at any time on `rd_data`. The usual way to update one field is read-modify-write. Only the divisor, select and halt bits are stored. The halt flag only stops the output while the stored divisor is non-zero. When the divisor is zero, a halt request leaves the output pulsing. A divisor change made while the divider runs waits until the period in progress has finished. A divisor written while the divider is halted is used from the first period after release.

Top module: `cdiv6_top`

## Requirements
- R1: While running, `tick_out` is high for exactly one cycle, in the cycle after the clock edge that samples the (N+1)-th qualifying tick of a period. N is the value of the divisor field at bits [5:0].
- R2: After reset, `rd_data` reads 0x013F: divisor 63, select 0, halt set. `tick_out` is low.
- R3: While the halt bit (bit 8) is set and the divisor field is non-zero, `tick_out` stays low whatever the sources do. After release, the first pulse follows N+1 fresh ticks.
- R4: While the divisor field is zero, setting the halt bit has no effect, and a pulse still follows every qualifying tick.
- R5: A write stores bits [5:0], [7:6] and 8. All other bits read back as zero. Without a write, `rd_data` holds its value, so a read-modify-write of one field leaves the other fields unchanged.
- R6: The select field at bits [7:6] picks `src_tick[index]`. An index at or above the number of implemented sources (3 by default) selects source 0.
- R7: A divisor written while the divider runs takes effect only after the current period completes, so no period is cut short.
- R8: A divisor written while the divider is halted and released governs the very first period after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to store |
| rd_data | output | 16 | Current control word |
| src_tick | input | 3 | Candidate source tick enables |
| tick_out | output | 1 | Divided tick, one cycle per period |

## Verification
The hardest situation to reach is a divisor change that lands in the middle of a running period. The test has to catch the counter part-way through, write the new value by read-modify-write, and confirm that the old count still completes before the new ratio applies. The stimulus starts from a halted state with a known divisor and releases it. It then feeds a counted number of ticks, so the pulse lands at a known place, and writes the new divisor on a cycle with no source tick. Every pulse after that point is compared against the expected tick index. A second case that is hard to reach is the ignored halt. For this, the divisor is first driven to zero while running, and then the halt bit is set.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int CDIV_REG_W    = 16;
  localparam int CDIV_DIV_W    = 6;
  localparam int CDIV_SEL_W    = 2;
  localparam int CDIV_SEL_LSB  = 6;
  localparam int CDIV_STOP_BIT = 8;
  localparam int CDIV_NSRC     = 3;

  // Mask of the bits that the control word actually stores.
  function automatic logic [CDIV_REG_W-1:0] cdiv_keep_mask(
    input int div_w, input int sel_w, input int sel_lsb, input int stop_bit);
    logic [CDIV_REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < CDIV_REG_W; i++) begin
      if (i < div_w) m[i] = 1'b1;
      if (i >= sel_lsb && i < sel_lsb + sel_w) m[i] = 1'b1;
      if (i == stop_bit) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cdiv_ctl_reg.sv
module cdiv_ctl_reg #(
  parameter int REG_W    = 16,
  parameter int DIV_W    = 6,
  parameter int SEL_W    = 2,
  parameter int SEL_LSB  = 6,
  parameter int STOP_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_d,
  output logic [SEL_W-1:0] sel_q,
  output logic             stop_q,
  output logic [REG_W-1:0] rd_data
);
  logic [SEL_W-1:0] sel_d;
  logic             stop_d;

  always_comb begin
    div_d  = wr_en ? wr_data[DIV_W-1:0]       : div_q;
    sel_d  = wr_en ? wr_data[SEL_LSB +: SEL_W] : sel_q;
    stop_d = wr_en ? wr_data[STOP_BIT]         : stop_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '1;
      sel_q  <= '0;
      stop_q <= 1'b1;
    end else begin
      div_q  <= div_d;
      sel_q  <= sel_d;
      stop_q <= stop_d;
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[DIV_W-1:0]         = div_q;
    rd_data[SEL_LSB +: SEL_W]  = sel_q;
    rd_data[STOP_BIT]          = stop_q;
  end
endmodule

// File: rtl/cdiv_src_pick.sv
module cdiv_src_pick #(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2
) (
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_sel
);
  logic [NSRC-1:0] hit;
  logic            in_range;

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i)) && src_tick[i];
  end

  assign in_range = int'(sel) < NSRC;
  assign tick_sel = in_range ? (|hit) : src_tick[0];
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             stop_q,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  output logic             tick_out
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act_div;
  logic             halted;
  logic             period_end;

  assign halted     = stop_q && (div_q != '0);
  assign period_end = tick_in && (cnt == act_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_div  <= '1;
      tick_out <= 1'b0;
    end else if (halted) begin
      cnt      <= '0;
      act_div  <= div_d;
      tick_out <= 1'b0;
    end else if (period_end) begin
      cnt      <= '0;
      act_div  <= div_q;
      tick_out <= 1'b1;
    end else begin
      if (tick_in) cnt <= cnt + 1'b1;
      tick_out <= 1'b0;
    end
  end
endmodule

// File: rtl/cdiv6_top.sv
module cdiv6_top #(
  parameter int REG_W    = cdiv_pkg::CDIV_REG_W,
  parameter int DIV_W    = cdiv_pkg::CDIV_DIV_W,
  parameter int SEL_W    = cdiv_pkg::CDIV_SEL_W,
  parameter int SEL_LSB  = cdiv_pkg::CDIV_SEL_LSB,
  parameter int STOP_BIT = cdiv_pkg::CDIV_STOP_BIT,
  parameter int NSRC     = cdiv_pkg::CDIV_NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick_out
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [SEL_W-1:0] sel_q;
  logic             stop_q;
  logic             tick_sel;

  cdiv_ctl_reg #(
    .REG_W(REG_W), .DIV_W(DIV_W), .SEL_W(SEL_W),
    .SEL_LSB(SEL_LSB), .STOP_BIT(STOP_BIT)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_q(div_q), .div_d(div_d), .sel_q(sel_q), .stop_q(stop_q),
    .rd_data(rd_data)
  );

  cdiv_src_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_pick (
    .src_tick(src_tick), .sel(sel_q), .tick_sel(tick_sel)
  );

  cdiv_core #(.DIV_W(DIV_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_sel), .stop_q(stop_q),
    .div_q(div_q), .div_d(div_d), .tick_out(tick_out)
  );
endmodule

// File: rtl/cdiv6_chk.sv
module cdiv6_chk #(
  parameter int REG_W    = 16,
  parameter int DIV_W    = 6,
  parameter int SEL_W    = 2,
  parameter int SEL_LSB  = 6,
  parameter int STOP_BIT = 8,
  parameter int NSRC     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [NSRC-1:0]  src_tick,
  input logic             tick_out,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] act_div
);
  localparam logic [REG_W-1:0] KEEP =
    cdiv_pkg::cdiv_keep_mask(DIV_W, SEL_W, SEL_LSB, STOP_BIT);

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[STOP_BIT] && (rd_data[DIV_W-1:0] != '0)) |=> !tick_out); // R3

  AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(|src_tick)); // R1

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == ($past(wr_data) & KEEP))); // R5

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R5

  AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_div); // R7
endmodule

bind cdiv6_top cdiv6_chk #(
  .REG_W(REG_W), .DIV_W(DIV_W), .SEL_W(SEL_W),
  .SEL_LSB(SEL_LSB), .STOP_BIT(STOP_BIT), .NSRC(NSRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .src_tick(src_tick), .tick_out(tick_out),
  .cnt(u_core.cnt), .act_div(u_core.act_div)
);

// File: tb/sim_cdiv6_top.sv
module sim_cdiv6_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  src_tick = '0;
  logic        tick_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cdiv6_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_tick(src_tick), .tick_out(tick_out)
  );

  // divisor, select index, window length
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 10}, '{1, 1, 24}, '{5, 2, 40},
    '{63, 0, 130}, '{2, 3, 30}, '{7, 1, 50}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v; src_tick = '0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // n cycles with every source ticking; pat bit i = tick_out after tick i+1
  task automatic run_all(input int n, output int pulses, output logic [63:0] pat);
    pulses = 0; pat = '0;
    for (int i = 0; i < n; i++) begin
      src_tick = 3'b111;
      @(posedge clk); @(negedge clk);
      pat[i] = tick_out;
      if (tick_out) pulses++;
    end
    src_tick = '0;
  endtask

  task automatic run_vec(input int d, input int s, input int w);
    int eff, ph, ticks, pulses, bad;
    logic t;
    wr(16'h013F);
    wr(16'(d) | 16'(s << 6));
    eff = (s >= 3) ? 0 : s;
    ticks = 0; pulses = 0; bad = 0; ph = 0;
    for (int c = 0; c < w; c++) begin
      src_tick[0] = 1'b1;
      src_tick[1] = (ph % 2) == 0;
      src_tick[2] = (ph % 3) == 0;
      t = src_tick[eff];
      @(posedge clk); @(negedge clk);
      if (t) ticks++;
      if (tick_out !== (t && (ticks % (d + 1) == 0))) bad++;
      if (tick_out) pulses++;
      ph++;
    end
    src_tick = '0;
    chk(bad == 0 && pulses == ticks / (d + 1), "R1 R6 R8 ratio/select/fresh start",
        pulses, ticks / (d + 1));
  endtask

  initial begin
    int p;
    logic [63:0] pat;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rd_data == 16'h013F, "R2 reset word", rd_data, 16'h013F);
    chk(tick_out == 1'b0, "R2 reset output", tick_out, 0);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k][0], VEC[k][1], VEC[k][2]);

    // R3: halted with non-zero divisor, then released
    wr(16'h0105);
    run_all(20, p, pat);
    chk(p == 0, "R3 halted output", p, 0);
    v = rd_data; v[8] = 1'b0; wr(v);
    run_all(6, p, pat);
    chk(p == 1 && pat[5], "R3 restart after 6 ticks", int'(pat[5:0]), 32);

    // R7: divisor change mid-period
    wr(16'h013F);
    wr(16'h0003);
    run_all(6, p, pat);
    chk(p == 1 && pat[3], "R7 first period of 4", int'(pat[5:0]), 8);
    v = rd_data; v[5:0] = 6'd0; wr(v);
    run_all(4, p, pat);
    chk(pat[3:0] == 4'b1110, "R7 old period completes first", int'(pat[3:0]), 14);

    // R4: halt ignored with zero divisor
    v = rd_data; v[8] = 1'b1; wr(v);
    chk(rd_data == 16'h0100, "R4 R5 halt bit stored", rd_data, 16'h0100);
    run_all(8, p, pat);
    chk(p == 8, "R4 still pulsing", p, 8);
    v = rd_data; v[5:0] = 6'd4; wr(v);
    chk(rd_data == 16'h0104, "R5 rmw keeps halt", rd_data, 16'h0104);
    run_all(10, p, pat);
    chk(p == 0, "R3 halt now honoured", p, 0);

    // R5: unused bits and field preservation
    wr(16'hFFFF);
    chk(rd_data == 16'h01FF, "R5 unused bits zero", rd_data, 16'h01FF);
    v = rd_data; v[5:0] = 6'd2; wr(v);
    chk(rd_data == 16'h01C2, "R5 rmw keeps select", rd_data, 16'h01C2);
    repeat (3) @(negedge clk);
    chk(rd_data == 16'h01C2, "R5 word holds", rd_data, 16'h01C2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule